// File: doc/BRIEF.md
# Receiver Error Logger and Sample Guard

This block sits behind a digital audio receiver's decoder. Each decoded sample arrives with four error indications: PLL unlock, validity, biphase coding error and parity error. The block derives a confidence flag from these and gates every flag through a per-bit unmask register. Unmasked errors are logged into a sticky flag register that clears when the control port reads it. Each sample carrying an unmasked error produces a single-cycle pulse, and an interrupt level stays high while any logged flag remains set.

The same unmasked-error decision sets the fate of the sample. A two-bit policy field chooses one of three actions: repeat the last clean sample, mute to zero, or pass the sample unchanged.

Samples travel over a valid/ready stream with one register stage. An input sample is accepted on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or is being drained in the same cycle. While `m_valid` is high and `m_ready` is low, the output sample is frozen and no new sample is taken.

Top module: `rx_fault_guard`

## Requirements
- R1: After reset `err_flags`, `err_pulse`, `err_irq` and `m_valid` are 0 and `s_ready` is 1. Flag and mask bit positions are: bit 0 parity, bit 1 biphase, bit 2 confidence, bit 3 validity, bit 4 unlock.
- R2: The confidence flag of a sample is the OR of its biphase and unlock inputs. Like every other flag, it is gated by its own mask bit.
- R3: A logged flag stays set until a cycle in which `err_rd` is high. It reads 0 from the following cycle.
- R4: When an accepted sample has a flag whose mask bit is 1, that flag is set in `err_flags`. `err_pulse` is high for exactly one cycle, which is the cycle in which that sample appears at the output.
- R5: A flag whose mask bit is 0 is not logged and raises no pulse or interrupt. If no unmasked flag is present, the sample passes through unchanged.
- R6: With `hold_mode` = 00, a sample with an unmasked error is replaced by the last clean output sample. That value is 0 after reset.
- R7: With `hold_mode` = 01, a sample with an unmasked error is output as zero.
- R8: With `hold_mode` = 10 or 11, a sample with an unmasked error is output unchanged.
- R9: The remembered clean sample is updated only by samples that carry no unmasked error.
- R10: An unmasked error accepted in the same cycle as `err_rd` leaves its flag set after the clear. Flags set only before that cycle are cleared.
- R11: `err_irq` is high exactly while any bit of `err_flags` is set, so it falls the cycle after a read.
- R12: `s_ready` equals `!m_valid || m_ready`. While `m_valid && !m_ready`, `m_data` holds its value.
- R13: An accepted sample appears on `m_data` with `m_valid` high in the cycle after acceptance. Its flags, pulse and interrupt appear in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample ready |
| s_data | input | SAMPLE_W | Decoded audio sample |
| s_unlock | input | 1 | PLL unlock indication for this sample |
| s_invalid | input | 1 | Validity indication for this sample |
| s_biphase | input | 1 | Biphase coding error for this sample |
| s_parity | input | 1 | Parity error for this sample |
| err_mask | input | 5 | Per-flag unmask bits (1 = reported) |
| hold_mode | input | 2 | Errored-sample policy |
| err_rd | input | 1 | Control-port read strobe, clears flags |
| err_flags | output | 5 | Sticky error flags |
| err_pulse | output | 1 | One-cycle pulse per errored sample |
| err_irq | output | 1 | Interrupt level |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Output sample ready |
| m_data | output | SAMPLE_W | Processed audio sample |

## Verification
Every result of an accepted sample is due one clock after the accepting edge: the output sample, the flag bits, the pulse and the interrupt. The pulse must be gone one clock later. The bench drives inputs on falling edges and samples on the falling edge that follows the accepting rising edge, then checks the pulse again one edge later. The effect of a read strobe is checked on the falling edge after the strobe's rising edge. Under back-pressure the frozen output is sampled on each stalled cycle, and the replacement sample is checked one cycle after `m_ready` returns.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  localparam int NFLAG   = 5;
  localparam int FL_PAR  = 0;
  localparam int FL_BIP  = 1;
  localparam int FL_CONF = 2;
  localparam int FL_VAL  = 3;
  localparam int FL_UNL  = 4;

  typedef enum logic [1:0] {
    POL_REPEAT = 2'b00,
    POL_MUTE   = 2'b01,
    POL_PASS   = 2'b10,
    POL_PASS_X = 2'b11
  } policy_e;
endpackage

// File: rtl/rxg_classify.sv
module rxg_classify
  import rxg_pkg::*;
(
  input  logic             unlock,
  input  logic             invalid,
  input  logic             biphase,
  input  logic             parity,
  input  logic [NFLAG-1:0] mask,
  output logic [NFLAG-1:0] hit,
  output logic             hit_any
);
  logic [NFLAG-1:0] raw;

  always_comb begin
    raw          = '0;
    raw[FL_PAR]  = parity;
    raw[FL_BIP]  = biphase;
    raw[FL_CONF] = biphase | unlock;
    raw[FL_VAL]  = invalid;
    raw[FL_UNL]  = unlock;
    hit          = raw & mask;
    hit_any      = |hit;
  end
endmodule

// File: rtl/rxg_sticky.sv
module rxg_sticky
  import rxg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [NFLAG-1:0] set_vec,
  input  logic             rd_clr,
  output logic [NFLAG-1:0] flags,
  output logic             pulse,
  output logic             irq
);
  genvar i;
  generate
    for (i = 0; i < NFLAG; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n) flags[i] <= 1'b0;
        else if (rd_clr || (set_en && set_vec[i])) flags[i] <= set_en && set_vec[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= set_en && (|set_vec);
  end

  assign irq = |flags;

  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((flags & $past(flags)) == $past(flags)));

  assert_pulse_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> irq);
endmodule

// File: rtl/rxg_hold.sv
module rxg_hold
  import rxg_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_data,
  input  logic                hit_any,
  input  logic [1:0]          mode,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [SAMPLE_W-1:0] m_data
);
  logic [SAMPLE_W-1:0] last_q;
  logic [SAMPLE_W-1:0] next_data;
  logic                accept;

  assign s_ready = !m_valid || m_ready;
  assign accept  = s_valid && s_ready;

  always_comb begin
    next_data = s_data;
    if (hit_any) begin
      case (policy_e'(mode))
        POL_REPEAT: next_data = last_q;
        POL_MUTE:   next_data = '0;
        default:    next_data = s_data;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      last_q  <= '0;
    end else if (accept) begin
      m_valid <= 1'b1;
      m_data  <= next_data;
      if (!hit_any) last_q <= s_data;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  assert_stall_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  assert_clean_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit_any) |=> (m_data == $past(s_data)));
endmodule

// File: rtl/rx_fault_guard.sv
module rx_fault_guard
  import rxg_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_data,
  input  logic                s_unlock,
  input  logic                s_invalid,
  input  logic                s_biphase,
  input  logic                s_parity,
  input  logic [4:0]          err_mask,
  input  logic [1:0]          hold_mode,
  input  logic                err_rd,
  output logic [4:0]          err_flags,
  output logic                err_pulse,
  output logic                err_irq,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [SAMPLE_W-1:0] m_data
);
  logic [NFLAG-1:0] hit;
  logic             hit_any;
  logic             accept;

  assign accept = s_valid && s_ready;

  rxg_classify u_cls (
    .unlock  (s_unlock),
    .invalid (s_invalid),
    .biphase (s_biphase),
    .parity  (s_parity),
    .mask    (err_mask),
    .hit     (hit),
    .hit_any (hit_any)
  );

  rxg_sticky u_log (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (accept),
    .set_vec (hit),
    .rd_clr  (err_rd),
    .flags   (err_flags),
    .pulse   (err_pulse),
    .irq     (err_irq)
  );

  rxg_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_data  (s_data),
    .hit_any (hit_any),
    .mode    (hold_mode),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data)
  );

  assert_pulse_with_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> m_valid);

  assert_masked_conf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !err_rd && err_mask[FL_CONF] && (s_biphase || s_unlock)) |=> err_flags[FL_CONF]);
endmodule

// File: tb/tb_rx_fault_guard.sv
module tb_rx_fault_guard;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [SW-1:0] s_data = '0;
  logic          s_unlock = 1'b0, s_invalid = 1'b0, s_biphase = 1'b0, s_parity = 1'b0;
  logic [4:0]    err_mask = '0;
  logic [1:0]    hold_mode = '0;
  logic          err_rd = 1'b0;
  logic [4:0]    err_flags;
  logic          err_pulse, err_irq, m_valid;
  logic          m_ready = 1'b1;
  logic [SW-1:0] m_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [SW-1:0] exp_last = '0;
  logic [4:0]    exp_flags = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fault_guard #(.SAMPLE_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_unlock(s_unlock), .s_invalid(s_invalid), .s_biphase(s_biphase), .s_parity(s_parity),
    .err_mask(err_mask), .hold_mode(hold_mode), .err_rd(err_rd), .err_flags(err_flags),
    .err_pulse(err_pulse), .err_irq(err_irq), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // e: bit0 parity, bit1 biphase, bit2 validity, bit3 unlock
  function automatic logic [4:0] model_hit(input logic [3:0] e, input logic [4:0] mk);
    logic [4:0] raw;
    raw = {e[3], e[2], e[1] | e[3], e[1], e[0]};
    return raw & mk;
  endfunction

  function automatic logic [SW-1:0] model_out(input logic [SW-1:0] d, input logic hit, input logic [1:0] md);
    if (!hit) return d;
    case (md)
      2'b00:   return exp_last;
      2'b01:   return '0;
      default: return d;
    endcase
  endfunction

  // called at a falling edge with m_ready high and the output register empty
  task automatic send(input logic [SW-1:0] d, input logic [3:0] e, input logic rd, input string req);
    logic [4:0] h;
    logic [SW-1:0] eo;
    h  = model_hit(e, err_mask);
    eo = model_out(d, |h, hold_mode);
    s_valid = 1'b1; s_data = d;
    {s_unlock, s_invalid, s_biphase, s_parity} = e;
    err_rd = rd;
    @(negedge clk);
    s_valid = 1'b0; err_rd = 1'b0;
    {s_unlock, s_invalid, s_biphase, s_parity} = '0;
    exp_flags = (rd ? 5'b0 : exp_flags) | h;
    if (!(|h)) exp_last = d;
    chk({req, " R13 valid"}, 32'(m_valid), 32'd1);
    chk({req, " data"}, 32'(m_data), 32'(eo));
    chk({req, " R4 flags"}, 32'(err_flags), 32'(exp_flags));
    chk({req, " R4 pulse"}, 32'(err_pulse), 32'(|h));
    chk({req, " R11 irq"}, 32'(err_irq), 32'(|exp_flags));
    @(negedge clk);
    chk("R4 pulse one cycle", 32'(err_pulse), 32'd0);
    chk("R12 drained", 32'(m_valid), 32'd0);
  endtask

  task automatic do_read();
    chk("R3 flags before read", 32'(err_flags), 32'(exp_flags));
    err_rd = 1'b1;
    @(negedge clk);
    err_rd = 1'b0;
    exp_flags = '0;
    chk("R3 cleared after read", 32'(err_flags), 32'd0);
    chk("R11 irq after read", 32'(err_irq), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 flags", 32'(err_flags), 32'd0);
    chk("R1 pulse", 32'(err_pulse), 32'd0);
    chk("R1 irq", 32'(err_irq), 32'd0);
    chk("R1 m_valid", 32'(m_valid), 32'd0);
    chk("R1 s_ready", 32'(s_ready), 32'd1);

    // R6 after reset: repeat policy yields 0 before any clean sample
    err_mask = 5'b00001; hold_mode = 2'b00;
    send(16'hABCD, 4'b0001, 1'b0, "R6 reset prev");
    do_read();

    // Sweep R2 R5 R6 R7 R8 R9: all policies, all masks, all error combos
    for (int md = 0; md < 4; md++) begin
      for (int mk = 0; mk < 32; mk++) begin
        hold_mode = 2'(md);
        err_mask  = 5'(mk);
        for (int e = 0; e < 16; e++) begin
          send(SW'(md * 4001 + mk * 17 + e + 1), 4'(e), 1'b0, "R2/R5-R9 sweep");
        end
        do_read();
      end
    end

    // R10: read strobe coincident with a new error
    err_mask = 5'b11111; hold_mode = 2'b10;
    send(16'h1111, 4'b0001, 1'b0, "R10 preset");
    chk("R10 preset parity", 32'(err_flags), 32'h01);
    send(16'h2222, 4'b0100, 1'b1, "R10 coincident");
    chk("R10 only new flag", 32'(err_flags), 32'h08);
    do_read();

    // R2: confidence alone unmasked, driven by unlock only
    err_mask = 5'b00100;
    send(16'h3333, 4'b1000, 1'b0, "R2 conf from unlock");
    chk("R2 conf flag", 32'(err_flags), 32'h04);
    do_read();

    // R12: back-pressure
    err_mask = 5'b00000; hold_mode = 2'b00;
    m_ready = 1'b0;
    s_valid = 1'b1; s_data = 16'h5A5A;
    @(negedge clk);
    s_data = 16'hC3C3;
    for (int k = 0; k < 3; k++) begin
      chk("R12 stall valid", 32'(m_valid), 32'd1);
      chk("R12 stall data", 32'(m_data), 32'h5A5A);
      chk("R12 stall ready", 32'(s_ready), 32'd0);
      @(negedge clk);
    end
    m_ready = 1'b1;
    #1;
    chk("R12 ready returns", 32'(s_ready), 32'd1);
    @(negedge clk);
    s_valid = 1'b0;
    chk("R12 next sample", 32'(m_data), 32'hC3C3);
    chk("R12 next valid", 32'(m_valid), 32'd1);
    @(negedge clk);
    chk("R12 empty", 32'(m_valid), 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule